// File: doc/BRIEF.md
# Programmable Memory Chip-Select Decoder

This block turns the page number of a memory access (the eight most significant bits of a 20-bit address, so 4 KB pages) into two active-low chip selects: one for a ROM device and one for a RAM device. Three 8-bit boundary registers set where each device sits. The ROM window always starts at page 0 and ends at a programmable top page. The RAM window has a programmable floor page and a programmable top page.

Software sets the boundaries through a small I/O register port with an address, write data, a write strobe, a read strobe and read data. The two windows may be set to overlap. Where they do, the ROM select is asserted and the RAM select is held inactive. A configuration input can switch ROM decoding off, so that RAM can be placed over the low part of the map. The selects are driven only while the memory request strobe is high, so I/O cycles never select a memory device. The page input must carry the CPU's own upper address bits, taken before any pin sharing on the address bus.

Top module: `mem_cs_decoder`

## Requirements
- R1: With mem_req high and cfg_rom_disable low, rom_cs_n is 0 exactly when mem_page is less than or equal to the ROM top register. The ROM floor is fixed at page 0.
- R2: With mem_req high, ram_cs_n is 0 exactly when the RAM floor register is less than or equal to mem_page, mem_page is less than or equal to the RAM top register, and rom_cs_n is 1.
- R3: When a page lies inside both windows, rom_cs_n is 0 and ram_cs_n is 1. The two selects are never low together.
- R4: A synchronous reset sets all three registers to FFh. After reset every page selects ROM and RAM is never selected.
- R5: While cfg_rom_disable is 1, rom_cs_n stays 1 and the RAM window decodes on its own.
- R6: While mem_req is 0, both rom_cs_n and ram_cs_n are 1 for any page.
- R7: The register map uses the low byte of the I/O address: E8h holds the ROM top, E6h the RAM floor and E7h the RAM top. A write to any other address changes no register. A read of any other address returns 00h.
- R8: A write with io_wr high is stored at that rising clock edge and is used for decoding from then on. While io_rd is high, io_rdata shows the value last written to the addressed register. While io_rd is low, io_rdata is 00h.
- R9: If the RAM floor register is greater than the RAM top register, ram_cs_n stays 1 for every page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; registers update on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| io_addr | input | 8 | Low byte of the I/O register address |
| io_wdata | input | 8 | Data for a register write |
| io_wr | input | 1 | Register write strobe |
| io_rd | input | 1 | Register read strobe |
| io_rdata | output | 8 | Register read data; 00h when no register is read |
| mem_page | input | 8 | Address bits 19 to 12 of the current memory access |
| mem_req | input | 1 | High during a memory cycle |
| cfg_rom_disable | input | 1 | Forces the ROM select inactive |
| rom_cs_n | output | 1 | ROM chip select, active low |
| ram_cs_n | output | 1 | RAM chip select, active low |

## Verification
The assertions assume that mem_req, mem_page and cfg_rom_disable are stable around the rising clock edge, because the selects are combinational and are sampled at that edge. They also assume that io_wr is a single-cycle pulse with io_addr and io_wdata held valid across it. The bench changes every input half a period away from the rising edge, pulses io_wr for exactly one cycle, and never drives io_wr and io_rd in the same cycle. It therefore stays inside those assumptions while it moves the boundaries into overlapping, touching and inverted arrangements.

// File: rtl/memcs_pkg.sv
package memcs_pkg;

    localparam int PAGE_W = 8;

    typedef logic [PAGE_W-1:0] page_t;

    // Boundary set held by the register file
    typedef struct packed {
        page_t rom_top;
        page_t ram_base;
        page_t ram_top;
    } bounds_t;

    // Raw window matches before priority is applied
    typedef struct packed {
        logic rom_hit;
        logic ram_hit;
    } hits_t;

    // Device chosen for the current cycle
    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_ROM  = 2'd1,
        TGT_RAM  = 2'd2
    } target_e;

    function automatic logic page_in_range(page_t p, page_t lo, page_t hi);
        return (p >= lo) && (p <= hi);
    endfunction

endpackage

// File: rtl/memcs_regfile.sv
module memcs_regfile
    import memcs_pkg::*;
#(
    parameter int              IO_ADDR_W  = 8,
    parameter logic [7:0]      ROM_TOP_AD = 8'hE8,
    parameter logic [7:0]      RAM_LO_AD  = 8'hE6,
    parameter logic [7:0]      RAM_HI_AD  = 8'hE7,
    parameter logic [PAGE_W-1:0] RST_VAL  = '1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [IO_ADDR_W-1:0] io_addr,
    input  logic [PAGE_W-1:0]    io_wdata,
    input  logic                 io_wr,
    input  logic                 io_rd,
    output logic [PAGE_W-1:0]    io_rdata,
    output bounds_t              bounds
);

    localparam int NREG = 3;
    localparam int IDX_ROM_TOP = 0;
    localparam int IDX_RAM_LO  = 1;
    localparam int IDX_RAM_HI  = 2;

    localparam logic [IO_ADDR_W-1:0] SLOT_AD [NREG] = '{
        IO_ADDR_W'(ROM_TOP_AD),
        IO_ADDR_W'(RAM_LO_AD),
        IO_ADDR_W'(RAM_HI_AD)
    };

    page_t          regs [NREG];
    logic [NREG-1:0] slot_hit;

    for (genvar g = 0; g < NREG; g++) begin : g_slot
        assign slot_hit[g] = (io_addr == SLOT_AD[g]);

        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= RST_VAL;
            end else if (io_wr && slot_hit[g]) begin
                regs[g] <= io_wdata;
            end
        end

        // R8: a write strobe to this slot lands the written byte
        assert_write_lands_R8 : assert property (@(posedge clk) disable iff (rst)
            (io_wr && slot_hit[g]) |=> (regs[g] == $past(io_wdata)));

        // R7: without a strobe addressed to it the slot keeps its value
        assert_slot_hold_R7 : assert property (@(posedge clk) disable iff (rst)
            !(io_wr && slot_hit[g]) |=> $stable(regs[g]));
    end

    always_comb begin
        io_rdata = '0;
        for (int i = 0; i < NREG; i++) begin
            if (io_rd && slot_hit[i]) begin
                io_rdata = regs[i];
            end
        end
    end

    assign bounds.rom_top  = regs[IDX_ROM_TOP];
    assign bounds.ram_base = regs[IDX_RAM_LO];
    assign bounds.ram_top  = regs[IDX_RAM_HI];

    // R8: read data is quiet when no read is requested
    assert_rdata_quiet_R8 : assert property (@(posedge clk) disable iff (rst)
        !io_rd |-> (io_rdata == '0));

endmodule

// File: rtl/memcs_window.sv
module memcs_window
    import memcs_pkg::*;
(
    input  page_t page,
    input  page_t floor_pg,
    input  page_t top_pg,
    output logic  hit
);

    assign hit = page_in_range(page, floor_pg, top_pg);

endmodule

// File: rtl/memcs_arbiter.sv
module memcs_arbiter
    import memcs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  mem_req,
    input  logic  rom_disable,
    input  hits_t hits,
    output logic  rom_cs_n,
    output logic  ram_cs_n
);

    target_e tgt;

    always_comb begin
        tgt = TGT_NONE;
        if (mem_req) begin
            if (hits.rom_hit && !rom_disable) begin
                tgt = TGT_ROM;
            end else if (hits.ram_hit) begin
                tgt = TGT_RAM;
            end
        end
    end

    assign rom_cs_n = (tgt != TGT_ROM);
    assign ram_cs_n = (tgt != TGT_RAM);

    // R3: the two selects are never low together
    assert_one_select_R3 : assert property (@(posedge clk) disable iff (rst)
        $countones({~rom_cs_n, ~ram_cs_n}) <= 1);

    // R6: no memory request, no select
    assert_idle_quiet_R6 : assert property (@(posedge clk) disable iff (rst)
        !mem_req |-> (rom_cs_n && ram_cs_n));

    // R5: the override keeps ROM off
    assert_rom_override_R5 : assert property (@(posedge clk) disable iff (rst)
        rom_disable |-> rom_cs_n);

    // R3: a ROM match with ROM enabled blocks the RAM select
    assert_rom_priority_R3 : assert property (@(posedge clk) disable iff (rst)
        (mem_req && hits.rom_hit && !rom_disable) |-> (!rom_cs_n && ram_cs_n));

endmodule

// File: rtl/mem_cs_decoder.sv
module mem_cs_decoder
    import memcs_pkg::*;
#(
    parameter int         IO_ADDR_W  = 8,
    parameter logic [7:0] ROM_TOP_AD = 8'hE8,
    parameter logic [7:0] RAM_LO_AD  = 8'hE6,
    parameter logic [7:0] RAM_HI_AD  = 8'hE7
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [IO_ADDR_W-1:0] io_addr,
    input  logic [PAGE_W-1:0]    io_wdata,
    input  logic                 io_wr,
    input  logic                 io_rd,
    output logic [PAGE_W-1:0]    io_rdata,
    input  logic [PAGE_W-1:0]    mem_page,
    input  logic                 mem_req,
    input  logic                 cfg_rom_disable,
    output logic                 rom_cs_n,
    output logic                 ram_cs_n
);

    localparam page_t ROM_FLOOR = '0;

    bounds_t bounds;
    hits_t   hits;

    memcs_regfile #(
        .IO_ADDR_W  (IO_ADDR_W),
        .ROM_TOP_AD (ROM_TOP_AD),
        .RAM_LO_AD  (RAM_LO_AD),
        .RAM_HI_AD  (RAM_HI_AD),
        .RST_VAL    ('1)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .io_addr  (io_addr),
        .io_wdata (io_wdata),
        .io_wr    (io_wr),
        .io_rd    (io_rd),
        .io_rdata (io_rdata),
        .bounds   (bounds)
    );

    memcs_window u_rom_win (
        .page     (mem_page),
        .floor_pg (ROM_FLOOR),
        .top_pg   (bounds.rom_top),
        .hit      (hits.rom_hit)
    );

    memcs_window u_ram_win (
        .page     (mem_page),
        .floor_pg (bounds.ram_base),
        .top_pg   (bounds.ram_top),
        .hit      (hits.ram_hit)
    );

    memcs_arbiter u_arb (
        .clk         (clk),
        .rst         (rst),
        .mem_req     (mem_req),
        .rom_disable (cfg_rom_disable),
        .hits        (hits),
        .rom_cs_n    (rom_cs_n),
        .ram_cs_n    (ram_cs_n)
    );

    // R9: an inverted RAM range never selects RAM
    assert_inverted_ram_R9 : assert property (@(posedge clk) disable iff (rst)
        (bounds.ram_base > bounds.ram_top) |-> ram_cs_n);

    // R1: ROM page at or below its top is selected when enabled
    assert_rom_low_page_R1 : assert property (@(posedge clk) disable iff (rst)
        (mem_req && !cfg_rom_disable && (mem_page <= bounds.rom_top)) |-> !rom_cs_n);

endmodule

// File: tb/tb_mem_cs_decoder.sv
module tb_mem_cs_decoder;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] io_addr;
    logic [7:0] io_wdata;
    logic       io_wr;
    logic       io_rd;
    logic [7:0] io_rdata;
    logic [7:0] mem_page;
    logic       mem_req;
    logic       cfg_rom_disable;
    logic       rom_cs_n;
    logic       ram_cs_n;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // bench copies of what was written
    logic [7:0] m_rom_top, m_ram_lo, m_ram_hi;

    always #(CLK_PERIOD/2) clk = ~clk;

    mem_cs_decoder dut (
        .clk             (clk),
        .rst             (rst),
        .io_addr         (io_addr),
        .io_wdata        (io_wdata),
        .io_wr           (io_wr),
        .io_rd           (io_rd),
        .io_rdata        (io_rdata),
        .mem_page        (mem_page),
        .mem_req         (mem_req),
        .cfg_rom_disable (cfg_rom_disable),
        .rom_cs_n        (rom_cs_n),
        .ram_cs_n        (ram_cs_n)
    );

    task automatic check(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr_reg(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
        if (a == 8'hE8) m_rom_top = d;
        if (a == 8'hE6) m_ram_lo  = d;
        if (a == 8'hE7) m_ram_hi  = d;
    endtask

    task automatic rd_check(string req, logic [7:0] a, logic [7:0] exp);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1;
        check(req, $sformatf("read %0h", a), io_rdata, exp);
        io_rd = 1'b0;
    endtask

    function automatic logic [1:0] model(logic [7:0] p, logic req, logic dis);
        logic rom, ram;
        rom = req && !dis && (p <= m_rom_top);
        ram = req && !rom && (p >= m_ram_lo) && (p <= m_ram_hi);
        return {~rom, ~ram};
    endfunction

    task automatic sel_check(string req, logic [7:0] p, logic rq, logic dis);
        logic [1:0] e;
        @(negedge clk);
        mem_page = p; mem_req = rq; cfg_rom_disable = dis;
        #1;
        e = model(p, rq, dis);
        check(req, $sformatf("selects page %0h req %0b dis %0b", p, rq, dis),
              {rom_cs_n, ram_cs_n}, e);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        m_rom_top = 8'hFF; m_ram_lo = 8'hFF; m_ram_hi = 8'hFF;
        rd_check("R4", 8'hE8, 8'hFF);
        rd_check("R4", 8'hE6, 8'hFF);
        rd_check("R4", 8'hE7, 8'hFF);
        sel_check("R4", 8'h00, 1'b1, 1'b0);
        sel_check("R4", 8'hFF, 1'b1, 1'b0);
        sel_check("R4", 8'h80, 1'b1, 1'b0);
    endtask

    task automatic t_rom_window();
        wr_reg(8'hE8, 8'h3F);
        wr_reg(8'hE6, 8'h40);
        wr_reg(8'hE7, 8'hFF);
        rd_check("R8", 8'hE8, 8'h3F);
        sel_check("R1", 8'h00, 1'b1, 1'b0);
        sel_check("R1", 8'h3F, 1'b1, 1'b0);
        sel_check("R1", 8'h40, 1'b1, 1'b0);
    endtask

    task automatic t_ram_window();
        wr_reg(8'hE8, 8'h0F);
        wr_reg(8'hE6, 8'h20);
        wr_reg(8'hE7, 8'h7F);
        sel_check("R2", 8'h1F, 1'b1, 1'b0);
        sel_check("R2", 8'h20, 1'b1, 1'b0);
        sel_check("R2", 8'h7F, 1'b1, 1'b0);
        sel_check("R2", 8'h80, 1'b1, 1'b0);
        sel_check("R2", 8'h10, 1'b1, 1'b0);
    endtask

    task automatic t_overlap();
        wr_reg(8'hE8, 8'h50);
        wr_reg(8'hE6, 8'h30);
        wr_reg(8'hE7, 8'h90);
        sel_check("R3", 8'h30, 1'b1, 1'b0);
        sel_check("R3", 8'h50, 1'b1, 1'b0);
        sel_check("R3", 8'h51, 1'b1, 1'b0);
    endtask

    task automatic t_override();
        sel_check("R5", 8'h10, 1'b1, 1'b1);
        sel_check("R5", 8'h40, 1'b1, 1'b1);
        sel_check("R5", 8'hA0, 1'b1, 1'b1);
    endtask

    task automatic t_idle();
        sel_check("R6", 8'h10, 1'b0, 1'b0);
        sel_check("R6", 8'h60, 1'b0, 1'b0);
        sel_check("R6", 8'h60, 1'b0, 1'b1);
    endtask

    task automatic t_regmap();
        wr_reg(8'hE9, 8'h00);
        wr_reg(8'h68, 8'h00);
        rd_check("R7", 8'hE8, m_rom_top);
        rd_check("R7", 8'hE6, m_ram_lo);
        rd_check("R7", 8'hE7, m_ram_hi);
        rd_check("R7", 8'hE9, 8'h00);
        @(negedge clk);
        io_addr = 8'hE8; io_rd = 1'b0;
        #1;
        check("R8", "rdata without read strobe", io_rdata, 8'h00);
    endtask

    task automatic t_write_timing();
        @(negedge clk);
        io_addr = 8'hE8; io_wdata = 8'h05; io_wr = 1'b1;
        mem_page = 8'h08; mem_req = 1'b1; cfg_rom_disable = 1'b0;
        #1;
        check("R8", "rom select before the write edge", rom_cs_n, 1'b0);
        @(negedge clk);
        io_wr = 1'b0;
        m_rom_top = 8'h05;
        #1;
        check("R8", "rom select after the write edge", rom_cs_n, 1'b1);
        rd_check("R8", 8'hE8, 8'h05);
    endtask

    task automatic t_inverted();
        wr_reg(8'hE8, 8'h00);
        wr_reg(8'hE6, 8'hC0);
        wr_reg(8'hE7, 8'hB0);
        sel_check("R9", 8'hB0, 1'b1, 1'b0);
        sel_check("R9", 8'hB8, 1'b1, 1'b0);
        sel_check("R9", 8'hC0, 1'b1, 1'b1);
    endtask

    initial begin
        rst = 1'b1; io_addr = '0; io_wdata = '0; io_wr = 1'b0; io_rd = 1'b0;
        mem_page = '0; mem_req = 1'b0; cfg_rom_disable = 1'b0;
        t_reset();
        t_rom_window();
        t_ram_window();
        t_overlap();
        t_override();
        t_idle();
        t_regmap();
        t_write_timing();
        t_inverted();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule